// File: doc/BRIEF.md
# Fiducial-Driven Event Sequencer

This block replays a short table of time-tagged event codes once per fiducial pulse. Each table slot holds an event code, a send time counted in clock cycles from the fiducial, and a stop flag. When a fiducial arrives, a cycle counter and a slot pointer restart. Each slot's code goes out on the cycle its time comes up. Slots are walked in address order, and a slot carrying the stop flag ends playback until the next fiducial. A typical table starts with the fiducial's own code at time zero.

The table is double banked so that the sequence can change from one pulse to the next. Software writes only the bank that is not playing. A commit strobe then arms a bank swap, which takes place at the next fiducial. Operator requests carry a code that must be sent as soon as possible. Such a code goes out one cycle after it is accepted. If a timed slot falls due on the same cycle, the timed code goes first and the request is held for one slot. The output stream feeds the event-code slot of a downstream frame multiplexer.

Top module: `fiducial_event_sequencer`

## Requirements
- R1: After reset, `ev_valid_o` is 0, `op_req_ready_o` is 1, and every slot of both banks holds the stop flag, so fiducials alone produce no output.
- R2: A slot in the playing bank with send time T drives `ev_valid_o`=1 with its code exactly T+1 clock edges after the edge that samples `fiducial_i`.
- R3: Slots play in ascending address order, starting from address 0, and each slot is sent at most once per fiducial period. Send times must rise strictly with address.
- R4: A slot whose stop flag (`seq_wr_stop_i`=1 at write time) is set is not sent, and neither is any slot after it, until the next fiducial.
- R5: A fiducial restarts playback from address 0 with the count at 0, even in the middle of a sequence. A slot that falls due on the fiducial edge itself is dropped.
- R6: Writes always land in the bank that is not playing. The playing bank changes only at a fiducial that follows a `seq_commit_i` pulse. Without a commit, the same bank replays on every fiducial.
- R7: An operator request accepted while `op_req_ready_o`=1, on an edge with no timed slot due, appears on the output with its code at the next edge.
- R8: When a timed slot and an accepted request share an edge, the timed code is sent first. The request is held, `op_req_ready_o` drops to 0, and the held code is sent at the first later edge with no timed slot due.
- R9: A request presented while `op_req_ready_o`=0 is dropped and never sent.
- R10: Once the last table address has been sent, playback stops until the next fiducial. It does not wrap around to address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Event clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fiducial_i | input | 1 | One-cycle fiducial pulse that restarts playback |
| seq_wr_en_i | input | 1 | Write strobe for the bank that is not playing |
| seq_wr_addr_i | input | ADDR_W | Slot address to write |
| seq_wr_code_i | input | CODE_W | Event code for the slot |
| seq_wr_time_i | input | TIME_W | Send time of the slot, in cycles after the fiducial |
| seq_wr_stop_i | input | 1 | Stop flag that ends playback at this slot |
| seq_commit_i | input | 1 | Arms a bank swap at the next fiducial |
| op_req_valid_i | input | 1 | Operator request present |
| op_req_code_i | input | CODE_W | Operator request code |
| op_req_ready_o | output | 1 | A request presented now will be accepted |
| ev_valid_o | output | 1 | An event code is on `ev_code_o` this cycle |
| ev_code_o | output | CODE_W | Event code out |

## Verification
The bench aims at three kinds of timing corner.

The first is the exact send cycle of a slot relative to the fiducial. A design one register off would put every code one cycle early or late.

The second is the collision between a timed slot and an operator request. The bench follows it with a second request while the first is still held. A wrong arbiter would lose the timed code, send both codes on one cycle, or let the dropped request through.

The third covers the bank rules. The bench issues a fiducial without a commit and rewrites the bank that is not playing. It also places a slot behind a stop flag, restarts in the middle of a sequence, and fills the table up to its last address. An early swap, a missing stop or a pointer that wraps would each change the count or the order of the codes in that period.

// File: rtl/fes_pkg.sv
package fes_pkg;
   typedef enum logic [1:0] {
      SRC_NONE  = 2'd0,
      SRC_TIMED = 2'd1,
      SRC_HELD  = 2'd2,
      SRC_LIVE  = 2'd3
   } fes_src_e;
endpackage

// File: rtl/fes_bank_store.sv
module fes_bank_store #(
   parameter int CODE_W = 8,
   parameter int TIME_W = 20,
   parameter int DEPTH  = 64,
   localparam int ADDR_W  = $clog2(DEPTH),
   localparam int ENTRY_W = CODE_W + TIME_W + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en_i,
   input  logic               wr_bank_i,
   input  logic [ADDR_W-1:0]  wr_addr_i,
   input  logic [ENTRY_W-1:0] wr_data_i,
   input  logic               rd_bank_i,
   input  logic [ADDR_W-1:0]  rd_addr_i,
   output logic [ENTRY_W-1:0] rd_data_o
);
   // Slot layout: {stop, time, code}; an empty slot carries only the stop flag
   localparam logic [ENTRY_W-1:0] EMPTY_SLOT = {1'b1, {(ENTRY_W-1){1'b0}}};

   logic [ENTRY_W-1:0] rd_word [2];

   for (genvar b = 0; b < 2; b++) begin : g_bank
      logic [ENTRY_W-1:0] mem_q [DEPTH];
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= EMPTY_SLOT;
         end else if (wr_en_i && (wr_bank_i == 1'(b))) begin
            mem_q[wr_addr_i] <= wr_data_i;
         end
      end
      assign rd_word[b] = mem_q[rd_addr_i];
   end

   assign rd_data_o = rd_word[rd_bank_i];
endmodule

// File: rtl/fes_timebase.sv
module fes_timebase #(
   parameter int CODE_W = 8,
   parameter int TIME_W = 20,
   parameter int DEPTH  = 64,
   localparam int ADDR_W  = $clog2(DEPTH),
   localparam int ENTRY_W = CODE_W + TIME_W + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               fiducial_i,
   input  logic               commit_i,
   input  logic [ENTRY_W-1:0] rd_data_i,
   output logic [ADDR_W-1:0]  rd_addr_o,
   output logic               bank_o,
   output logic               hit_o,
   output logic [CODE_W-1:0]  hit_code_o
);
   logic [TIME_W-1:0] cnt_q;
   logic [ADDR_W-1:0] ptr_q;
   logic              run_q;
   logic              bank_q;
   logic              armed_q;

   logic              ent_stop;
   logic [TIME_W-1:0] ent_time;
   logic              at_last;

   assign ent_stop   = rd_data_i[ENTRY_W-1];
   assign ent_time   = rd_data_i[CODE_W +: TIME_W];
   assign hit_code_o = rd_data_i[CODE_W-1:0];
   assign at_last    = (ptr_q == ADDR_W'(DEPTH - 1));

   assign hit_o     = run_q && !fiducial_i && !ent_stop && (ent_time == cnt_q);
   assign rd_addr_o = ptr_q;
   assign bank_o    = bank_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         ptr_q   <= '0;
         run_q   <= 1'b0;
         bank_q  <= 1'b0;
         armed_q <= 1'b0;
      end else if (fiducial_i) begin
         cnt_q   <= '0;
         ptr_q   <= '0;
         run_q   <= 1'b1;
         if (armed_q) bank_q <= ~bank_q;
         armed_q <= commit_i;
      end else begin
         if (commit_i) armed_q <= 1'b1;
         if (!(&cnt_q)) cnt_q <= cnt_q + 1'b1;
         if (run_q) begin
            if (ent_stop) begin
               run_q <= 1'b0;
            end else if (hit_o) begin
               if (at_last) run_q <= 1'b0;
               else         ptr_q <= ptr_q + 1'b1;
            end
         end
      end
   end

   // R6: the playing bank changes only at a fiducial
   p_bank_hold_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      !fiducial_i |=> $stable(bank_q));
   // R3: the pointer only holds or steps forward by one between fiducials
   p_step_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      !fiducial_i |=> (ptr_q == $past(ptr_q)) || (ptr_q == $past(ptr_q) + 1'b1));
   // R5: a fiducial brings pointer and count back to zero
   p_restart_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      fiducial_i |=> (ptr_q == '0) && (cnt_q == '0) && run_q);
endmodule

// File: rtl/fes_out_merge.sv
module fes_out_merge
   import fes_pkg::*;
#(
   parameter int CODE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hit_i,
   input  logic [CODE_W-1:0] hit_code_i,
   input  logic              op_valid_i,
   input  logic [CODE_W-1:0] op_code_i,
   output logic              op_ready_o,
   output logic              ev_valid_o,
   output logic [CODE_W-1:0] ev_code_o
);
   logic              pend_q;
   logic [CODE_W-1:0] pend_code_q;
   logic              take;
   fes_src_e          src;

   assign op_ready_o = !pend_q;
   assign take       = op_valid_i && !pend_q;

   always_comb begin
      if (hit_i)       src = SRC_TIMED;
      else if (pend_q) src = SRC_HELD;
      else if (take)   src = SRC_LIVE;
      else             src = SRC_NONE;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ev_valid_o  <= 1'b0;
         ev_code_o   <= '0;
         pend_q      <= 1'b0;
         pend_code_q <= '0;
      end else begin
         ev_valid_o <= (src != SRC_NONE);
         unique case (src)
            SRC_TIMED: ev_code_o <= hit_code_i;
            SRC_HELD:  ev_code_o <= pend_code_q;
            SRC_LIVE:  ev_code_o <= op_code_i;
            default:   ev_code_o <= '0;
         endcase
         if (src == SRC_TIMED && take) begin
            pend_q      <= 1'b1;
            pend_code_q <= op_code_i;
         end else if (src == SRC_HELD) begin
            pend_q <= 1'b0;
         end
      end
   end

   p_op_immediate_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid_i && op_ready_o && !hit_i) |=> (ev_valid_o && ev_code_o == $past(op_code_i)));
   p_timed_wins_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      hit_i |=> (ev_valid_o && ev_code_o == $past(hit_code_i)));
   p_held_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      (hit_i && op_valid_i && op_ready_o) |=> !op_ready_o);
   p_drop_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid_i && !op_ready_o && !hit_i) |=> (op_ready_o && ev_valid_o));
endmodule

// File: rtl/fiducial_event_sequencer.sv
module fiducial_event_sequencer #(
   parameter int CODE_W = 8,
   parameter int TIME_W = 20,
   parameter int DEPTH  = 64,
   localparam int ADDR_W  = $clog2(DEPTH),
   localparam int ENTRY_W = CODE_W + TIME_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fiducial_i,
   input  logic              seq_wr_en_i,
   input  logic [ADDR_W-1:0] seq_wr_addr_i,
   input  logic [CODE_W-1:0] seq_wr_code_i,
   input  logic [TIME_W-1:0] seq_wr_time_i,
   input  logic              seq_wr_stop_i,
   input  logic              seq_commit_i,
   input  logic              op_req_valid_i,
   input  logic [CODE_W-1:0] op_req_code_i,
   output logic              op_req_ready_o,
   output logic              ev_valid_o,
   output logic [CODE_W-1:0] ev_code_o
);
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (CODE_W < 1 || TIME_W < 2) begin : g_bad_width
      $error("CODE_W must be at least 1 and TIME_W at least 2");
   end

   logic [ADDR_W-1:0]  rd_addr;
   logic [ENTRY_W-1:0] rd_data;
   logic               play_bank;
   logic               hit;
   logic [CODE_W-1:0]  hit_code;

   fes_bank_store #(.CODE_W(CODE_W), .TIME_W(TIME_W), .DEPTH(DEPTH)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en_i   (seq_wr_en_i),
      .wr_bank_i (~play_bank),
      .wr_addr_i (seq_wr_addr_i),
      .wr_data_i ({seq_wr_stop_i, seq_wr_time_i, seq_wr_code_i}),
      .rd_bank_i (play_bank),
      .rd_addr_i (rd_addr),
      .rd_data_o (rd_data)
   );

   fes_timebase #(.CODE_W(CODE_W), .TIME_W(TIME_W), .DEPTH(DEPTH)) u_time (
      .clk        (clk),
      .rst_n      (rst_n),
      .fiducial_i (fiducial_i),
      .commit_i   (seq_commit_i),
      .rd_data_i  (rd_data),
      .rd_addr_o  (rd_addr),
      .bank_o     (play_bank),
      .hit_o      (hit),
      .hit_code_o (hit_code)
   );

   fes_out_merge #(.CODE_W(CODE_W)) u_merge (
      .clk        (clk),
      .rst_n      (rst_n),
      .hit_i      (hit),
      .hit_code_i (hit_code),
      .op_valid_i (op_req_valid_i),
      .op_code_i  (op_req_code_i),
      .op_ready_o (op_req_ready_o),
      .ev_valid_o (ev_valid_o),
      .ev_code_o  (ev_code_o)
   );
endmodule

// File: tb/test_fiducial_event_sequencer.sv
module test_fiducial_event_sequencer;
   localparam int CLK_PERIOD = 10;
   localparam int CW = 8;
   localparam int TW = 16;
   localparam int DP = 8;
   localparam int AW = $clog2(DP);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          fid = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [CW-1:0] wr_code = '0;
   logic [TW-1:0] wr_time = '0;
   logic          wr_stop = 1'b0;
   logic          commit = 1'b0;
   logic          op_v = 1'b0;
   logic [CW-1:0] op_code = '0;
   logic          op_ready;
   logic          ev_valid;
   logic [CW-1:0] ev_code;

   always #(CLK_PERIOD/2) clk = ~clk;

   fiducial_event_sequencer #(.CODE_W(CW), .TIME_W(TW), .DEPTH(DP)) i_fiducial_event_sequencer (
      .clk(clk), .rst_n(rst_n), .fiducial_i(fid),
      .seq_wr_en_i(wr_en), .seq_wr_addr_i(wr_addr), .seq_wr_code_i(wr_code),
      .seq_wr_time_i(wr_time), .seq_wr_stop_i(wr_stop), .seq_commit_i(commit),
      .op_req_valid_i(op_v), .op_req_code_i(op_code), .op_req_ready_o(op_ready),
      .ev_valid_o(ev_valid), .ev_code_o(ev_code));

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   task automatic check(bit ok, string tag, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // ---------------- behavioural reference ----------------
   int  m_code [2][DP];
   int  m_time [2][DP];
   bit  m_stop [2][DP];
   int  m_cnt, m_ptr, m_pcode;
   bit  m_run, m_bank, m_armed, m_pend;
   bit  e_valid = 1'b0;
   int  e_code = 0;
   bit  e_ready = 1'b1;
   string e_tag = "R1";

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int b = 0; b < 2; b++)
            for (int i = 0; i < DP; i++) begin
               m_code[b][i] = 0; m_time[b][i] = 0; m_stop[b][i] = 1'b1;
            end
         m_cnt = 0; m_ptr = 0; m_run = 0; m_bank = 0; m_armed = 0; m_pend = 0; m_pcode = 0;
         e_valid = 0; e_code = 0; e_ready = 1; e_tag = "R1";
      end else begin
         bit due, take;
         due  = m_run && !fid && !m_stop[m_bank][m_ptr] && (m_time[m_bank][m_ptr] == m_cnt);
         take = op_v && !m_pend;
         if (due) begin
            e_valid = 1; e_code = m_code[m_bank][m_ptr]; e_tag = "R2";
            if (take) begin m_pend = 1; m_pcode = int'(op_code); end
         end else if (m_pend) begin
            e_valid = 1; e_code = m_pcode; e_tag = "R8"; m_pend = 0;
         end else if (take) begin
            e_valid = 1; e_code = int'(op_code); e_tag = "R7";
         end else begin
            e_valid = 0; e_code = 0; e_tag = op_v ? "R9" : "R4";
         end
         e_ready = !m_pend;
         if (fid) begin
            m_cnt = 0; m_ptr = 0; m_run = 1;
            if (m_armed) m_bank = !m_bank;
            m_armed = commit;
         end else begin
            if (commit) m_armed = 1;
            if (m_cnt < (1 << TW) - 1) m_cnt++;
            if (m_run) begin
               if (m_stop[m_bank][m_ptr]) m_run = 0;
               else if (due) begin
                  if (m_ptr == DP - 1) m_run = 0; else m_ptr++;
               end
            end
         end
         if (wr_en) begin
            m_code[!m_bank][wr_addr] = int'(wr_code);
            m_time[!m_bank][wr_addr] = int'(wr_time);
            m_stop[!m_bank][wr_addr] = wr_stop;
         end
      end
   end

   // ---------------- per-cycle compare and window monitor ----------------
   bit counting = 1'b0;
   int win_cnt = 0;
   int win_codes [64];

   always @(negedge clk) begin
      if (rst_n && !done) begin
         check(ev_valid == e_valid, e_tag, ev_valid, e_valid);
         if (e_valid) check(int'(ev_code) == e_code, e_tag, ev_code, e_code);
         check(op_ready == e_ready, "R8", op_ready, e_ready);
         if (counting && ev_valid) begin
            if (win_cnt < 64) win_codes[win_cnt] = int'(ev_code);
            win_cnt++;
         end
      end
   end

   task automatic tick(int n = 1);
      repeat (n) @(negedge clk);
   endtask

   task automatic put(int a, int c, int t, bit s);
      wr_en = 1; wr_addr = AW'(a); wr_code = CW'(c); wr_time = TW'(t); wr_stop = s;
      tick();
      wr_en = 0; wr_stop = 0;
   endtask

   task automatic pulse_fid();
      fid = 1; tick(); fid = 0;
   endtask

   task automatic pulse_commit();
      commit = 1; tick(); commit = 0;
   endtask

   task automatic window_start();
      win_cnt = 0; counting = 1;
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++; errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : stim
      tick(3);
      rst_n = 1;
      tick();
      // R1: reset state at the ports
      check(ev_valid == 1'b0, "R1", ev_valid, 0);
      check(op_ready == 1'b1, "R1", op_ready, 1);
      window_start(); pulse_fid(); tick(30); counting = 0;
      check(win_cnt == 0, "R1", win_cnt, 0);

      // R6: written bank does not play before commit
      put(0, 8'h01, 0, 0);
      put(1, 8'h10, 5, 0);
      put(2, 8'h20, 9, 0);
      put(3, 8'h00, 0, 1);
      window_start(); pulse_fid(); tick(20); counting = 0;
      check(win_cnt == 0, "R6", win_cnt, 0);

      // R2: committed bank plays at T+1 cycles (per-cycle compare covers the timing)
      pulse_commit();
      window_start(); pulse_fid(); tick(20); counting = 0;
      check(win_cnt == 3, "R2", win_cnt, 3);
      check(win_codes[0] == 8'h01 && win_codes[1] == 8'h10 && win_codes[2] == 8'h20,
            "R3", win_codes[1], 8'h10);

      // R8 collision with the time-5 slot, R9 request dropped while held
      window_start(); pulse_fid();
      tick(5);
      op_v = 1; op_code = 8'hA1; tick();
      check(op_ready == 1'b0, "R8", op_ready, 0);
      op_code = 8'hA2; tick();
      op_v = 0; tick(15); counting = 0;
      check(win_cnt == 4, "R9", win_cnt, 4);
      check(win_codes[1] == 8'h10 && win_codes[2] == 8'hA1, "R8", win_codes[2], 8'hA1);

      // R7: idle request goes straight out
      op_v = 1; op_code = 8'hB3; tick(); op_v = 0;
      check(ev_valid == 1'b1 && ev_code == 8'hB3, "R7", ev_code, 8'hB3);
      tick(3);

      // R5: restart before the time-9 slot
      window_start(); pulse_fid(); tick(6); pulse_fid();
      check(win_cnt == 2, "R5", win_cnt, 2);
      tick(20); counting = 0;
      check(win_cnt == 5, "R5", win_cnt, 5);

      // R6: rewrite the idle bank, no commit: old sequence continues
      for (int i = 0; i < DP; i++) put(i, 8'h40 + i, 2 * i + 2, 0);
      window_start(); pulse_fid(); tick(30); counting = 0;
      check(win_cnt == 3, "R6", win_cnt, 3);

      // R10 and R3: full table, ascending order, no wrap
      pulse_commit();
      window_start(); pulse_fid(); tick(60); counting = 0;
      check(win_cnt == DP, "R10", win_cnt, DP);
      for (int i = 0; i < DP; i++)
         check(win_codes[i] == 8'h40 + i, "R3", win_codes[i], 8'h40 + i);

      // R4: slot behind a stop flag never plays
      put(0, 8'h01, 0, 0);
      put(1, 8'h11, 3, 0);
      put(2, 8'h00, 0, 1);
      put(3, 8'h55, 12, 0);
      pulse_commit();
      window_start(); pulse_fid(); tick(40); counting = 0;
      check(win_cnt == 2, "R4", win_cnt, 2);
      check(win_codes[1] == 8'h11, "R4", win_codes[1], 8'h11);

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule